// File: doc/BRIEF.md
# Lookahead Peek Register File

This block is a small storage array with one synchronous write port and two combinational read outputs. The first output returns the word at the read pointer. The second output, the peek, returns the word one entry ahead of that pointer, with wrap-around at the top of the array. The peek has no address input of its own. Its address is always derived from the read pointer.

A stream decoder uses the block to see the current word and the following word in the same cycle. A field that straddles a word boundary can then be assembled without a second access. The default build is four entries of 32 bits. Width and depth are parameters, and the depth must be a power of two.

Top module: `lkp_regfile`

## Requirements
- R1: With default parameters the array holds 4 entries of 32 bits each, and every address port is 2 bits wide.
- R2: `rd_data` equals the entry selected by `rd_addr` in the same cycle, with no clock of latency.
- R3: On a rising clock edge with `wr` = 1, `wr_data` is stored at `wr_addr`, and both outputs show the new value from that edge onward.
- R4: On a rising clock edge with `wr` = 0, no entry changes. Both outputs stay stable while `rd_addr` is held.
- R5: `peek` equals the entry at (`rd_addr` + 1) modulo the depth in the same cycle, with no clock of latency.
- R6: When `rd_addr` is the last address (3 by default), `peek` shows entry 0.
- R7: While a write to the address seen by `rd_data` or `peek` is pending, that output shows the old contents. It changes to the new contents only at the clock edge. There is no write-through bypass.
- R8: A write changes only the addressed entry. All other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| wr | input | 1 | Write enable |
| wr_addr | input | 2 | Entry to write |
| wr_data | input | 32 | Data to store |
| rd_addr | input | 2 | Read pointer |
| rd_data | output | 32 | Entry at the read pointer |
| peek | output | 32 | Entry one ahead of the read pointer, wrapping |

## Verification
The bench builds the block with its default parameters: four entries of 32 bits. With only four addresses, every read pointer value can be visited, including the wrap from the last entry to entry 0. A write can also be aimed at every read/peek overlap, and a write to one entry can be checked against all three others. The bench keeps its own reference copy of the array. It computes the peek address with its own modulo step rather than the design's helper function.

// File: rtl/lkp_pkg.sv
package lkp_pkg;

  // Step an address forward by a given distance, wrapping at the array depth.
  function automatic int unsigned lkp_step(input int unsigned addr,
                                           input int unsigned step,
                                           input int unsigned depth);
    int unsigned sum;
    sum = addr + step;
    while (sum >= depth) sum = sum - depth;
    return sum;
  endfunction

  // Address width for a given depth (at least one bit).
  function automatic int unsigned lkp_aw(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/lkp_store.sv
module lkp_store #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = lkp_pkg::lkp_aw(DEPTH)
) (
  input  logic                         clk,
  input  logic                         wr,
  input  logic [AW-1:0]                wr_addr,
  input  logic [WIDTH-1:0]             wr_data,
  output logic [DEPTH-1:0]             wr_sel,
  output logic [DEPTH-1:0][WIDTH-1:0]  cells
);

  // One-hot write decode, one flop row per entry.
  for (genvar e = 0; e < DEPTH; e++) begin : g_row
    assign wr_sel[e] = wr && (wr_addr == AW'(e));

    always_ff @(posedge clk) begin
      if (wr_sel[e]) cells[e] <= wr_data;
    end
  end

endmodule

// File: rtl/lkp_read_port.sv
module lkp_read_port #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned OFFSET = 0,
  localparam int unsigned AW = lkp_pkg::lkp_aw(DEPTH)
) (
  input  logic [DEPTH-1:0][WIDTH-1:0]  cells,
  input  logic [AW-1:0]                base_addr,
  output logic [AW-1:0]                eff_addr,
  output logic [WIDTH-1:0]             data
);

  always_comb begin
    eff_addr = AW'(lkp_pkg::lkp_step(int'(base_addr), OFFSET, DEPTH));
    data     = cells[eff_addr];
  end

endmodule

// File: rtl/lkp_regfile.sv
module lkp_regfile #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = lkp_pkg::lkp_aw(DEPTH),
  localparam int unsigned NPORT = 2
) (
  input  logic             clk,
  input  logic             wr,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic [WIDTH-1:0] peek
);

  logic [DEPTH-1:0][WIDTH-1:0] cells;
  logic [DEPTH-1:0]            wr_sel;
  logic [NPORT-1:0][AW-1:0]    port_addr;
  logic [NPORT-1:0][WIDTH-1:0] port_data;

  // Named events for the checker.
  logic [AW-1:0] peek_addr;
  logic          wr_hits_rd;
  logic          wr_hits_peek;

  lkp_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr      (wr),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_sel  (wr_sel),
    .cells   (cells)
  );

  // Port 0 reads at the pointer, port 1 one entry ahead.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    lkp_read_port #(.WIDTH(WIDTH), .DEPTH(DEPTH), .OFFSET(p)) u_port (
      .cells     (cells),
      .base_addr (rd_addr),
      .eff_addr  (port_addr[p]),
      .data      (port_data[p])
    );
  end

  assign rd_data      = port_data[0];
  assign peek         = port_data[1];
  assign peek_addr    = port_addr[1];
  assign wr_hits_rd   = wr_sel[port_addr[0]];
  assign wr_hits_peek = wr_sel[port_addr[1]];

endmodule

// File: rtl/lkp_regfile_chk.sv
module lkp_regfile_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = lkp_pkg::lkp_aw(DEPTH)
) (
  input logic             clk,
  input logic             wr,
  input logic [AW-1:0]    wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [AW-1:0]    rd_addr,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] peek,
  input logic [AW-1:0]    peek_addr,
  input logic             wr_hits_rd,
  input logic             wr_hits_peek
);

  // No reset port: properties stay off until one edge has passed.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!armed)
    $past(wr_hits_rd) && $stable(rd_addr) |-> rd_data == $past(wr_data)); // R3

  AST_PEEK_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!armed)
    $past(wr_hits_peek) && $stable(rd_addr) |-> peek == $past(wr_data)); // R7

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!armed)
    !$past(wr) && $stable(rd_addr) |-> $stable(rd_data) && $stable(peek)); // R4

  AST_PEEK_BECOMES_READ: assert property (@(posedge clk) disable iff (!armed)
    !$past(wr) && rd_addr == $past(peek_addr) |-> rd_data == $past(peek)); // R5

  AST_OTHER_UNTOUCHED: assert property (@(posedge clk) disable iff (!armed)
    $past(wr) && $stable(rd_addr) && rd_addr != $past(wr_addr)
      |-> $stable(rd_data)); // R8

endmodule

bind lkp_regfile lkp_regfile_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .wr           (wr),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .rd_addr      (rd_addr),
  .rd_data      (rd_data),
  .peek         (peek),
  .peek_addr    (peek_addr),
  .wr_hits_rd   (wr_hits_rd),
  .wr_hits_peek (wr_hits_peek)
);

// File: tb/tb_lkp_regfile.sv
module tb_lkp_regfile;

  localparam int W = 32;
  localparam int D = 4;
  localparam int A = 2;

  logic         clk = 1'b0;
  logic         wr = 1'b0;
  logic [A-1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [A-1:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] peek;

  logic [W-1:0] ref_mem [D];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lkp_regfile dut (.*);

  function automatic int ahead(input int a);
    return (a == D - 1) ? 0 : a + 1;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply one write over one edge; inputs change at negedge.
  task automatic do_write(input int a, input logic [W-1:0] d);
    @(negedge clk);
    wr = 1'b1; wr_addr = A'(a); wr_data = d;
    @(negedge clk);
    wr = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic check_pointer(input int a, input string tag);
    rd_addr = A'(a);
    #1;
    check({tag, " R2 rd_data"}, rd_data, ref_mem[a]);
    check({tag, " R5 peek"}, peek, ref_mem[ahead(a)]);
  endtask

  task automatic t_fill;
    for (int i = 0; i < D; i++) do_write(i, 32'hA000_0000 + i * 32'h0101_0101);
    for (int i = 0; i < D; i++) check_pointer(i, "fill R1");
  endtask

  task automatic t_wrap;
    @(negedge clk);
    rd_addr = A'(D - 1);
    #1;
    check("R6 wrap peek", peek, ref_mem[0]);
    check("R6 wrap rd", rd_data, ref_mem[D-1]);
  endtask

  task automatic t_no_write;
    @(negedge clk);
    rd_addr = 2'd1;
    wr = 1'b0; wr_addr = 2'd1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); @(negedge clk);
    #1;
    check("R4 rd unchanged", rd_data, ref_mem[1]);
    check("R4 peek unchanged", peek, ref_mem[2]);
  endtask

  task automatic t_rdw;
    // Write to the read address, and in a second pass to the peek address.
    for (int pass = 0; pass < 2; pass++) begin
      logic [W-1:0] nv;
      int tgt;
      nv  = 32'h5EED_0000 + pass;
      tgt = (pass == 0) ? 2 : ahead(2);
      @(negedge clk);
      rd_addr = 2'd2;
      wr = 1'b1; wr_addr = A'(tgt); wr_data = nv;
      #1;
      if (pass == 0) check("R7 rd old before edge", rd_data, ref_mem[2]);
      else           check("R7 peek old before edge", peek, ref_mem[tgt]);
      @(negedge clk);
      wr = 1'b0;
      ref_mem[tgt] = nv;
      #1;
      if (pass == 0) check("R3 rd new after edge", rd_data, nv);
      else           check("R7 peek new after edge", peek, nv);
    end
  endtask

  task automatic t_isolate;
    do_write(0, 32'h0BAD_CAFE);
    for (int i = 0; i < D; i++) check_pointer(i, "R8 isolate");
  endtask

  task automatic t_random;
    for (int n = 0; n < 40; n++) begin
      do_write(int'($urandom_range(D - 1)), $urandom);
      for (int i = 0; i < D; i++) check_pointer(i, "R3 random");
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_fill();
    t_wrap();
    t_no_write();
    t_rdw();
    t_isolate();
    t_wrap();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule